// File: doc/BRIEF.md
# Octet-Aligned Frame Check Sequence Verifier

This block checks the 32-bit cyclic redundancy code of a serial frame. Bits arrive one per clock on `rx_bit` while `rx_valid` is high. They are packed into octets, least significant bit first. Each octet is folded into the CRC register as soon as its eighth bit arrives, using an octet-wide next-state function. A bit that only starts an octet is held in the packer and does not touch the register.

When `rx_valid` drops, any partial octet left over is discarded. The last four complete octets act as the check field. The CRC register runs in multiply-and-divide form: each incoming bit is XORed with the register's top bit before the shift. Because of this, no 32 zero bits have to be appended and nothing of the frame is stored. After the check field, the register of a good frame holds a fixed residue. A one-cycle status pulse then reports pass or fail and the number of complete octets.

The control is a three-state machine:
- **IDLE**: the register is preset and no bit has been taken.
- **RECV**: a frame is being received.
- **REPORT**: the single status cycle.

The transitions are:
- **START** (IDLE to RECV): `rx_valid` is high.
- **HOLD** (RECV to RECV): `rx_valid` stays high.
- **FINISH** (RECV to REPORT): the first cycle in which `rx_valid` is sampled low.
- **REARM** (REPORT to IDLE): unconditional. The register, packer and octet tally are preset on this transition.

Top module: `fcs_octet_checker`

## Requirements
- R1: Bits are packed into octets with the first received bit in bit 0. The CRC register is preset to all ones and uses the generator 0x04C11DB7. For each bit of an octet, in order 0 to 7, the feedback is the register's bit 31 XOR the data bit. The register then shifts left by one, and the generator is XORed in when the feedback is 1. A frame passes when the register equals 0xC704DD7B after all complete octets. This is the case exactly when the last four octets carry the complement of the register taken over the preceding octets, with register bit 31 sent first (bit 0 of the first check octet).
- R2: One to seven bits that follow the last complete octet are ignored and do not change the pass/fail result.
- R3: The check field is the last four complete octets. A frame whose final 32 received bits hold a correct code that is not aligned to an octet boundary fails.
- R4: A frame with fewer than four complete octets fails. A frame of exactly four octets that hold the code of an empty message passes.
- R5: `status_valid` is high for exactly one cycle. That cycle follows the first clock edge that samples `rx_valid` low after a frame. `frame_ok` and `octet_count` carry the result only in that cycle and are zero in every other cycle.
- R6: `octet_count` equals the number of complete octets received in the frame.
- R7: A frame with any single payload bit inverted fails.
- R8: `rx_valid` is ignored during the status cycle. A frame that starts on the next cycle is checked from a freshly preset register, so frames can follow each other with only one low cycle between them.
- R9: A synchronous reset aborts any frame in progress. It clears the partial-octet fill and returns the CRC register to its preset. No status pulse follows, and the next frame is checked correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit | input | 1 | Serial data bit |
| rx_valid | input | 1 | High while frame bits are present |
| status_valid | output | 1 | One-cycle end-of-frame pulse |
| frame_ok | output | 1 | Check result, valid with `status_valid` |
| octet_count | output | CNT_W | Complete octets in the frame, valid with `status_valid` |

## Verification
The main function is tried with several kinds of frame:
- Aligned good frames of several lengths, which separate a correct CRC from a wrong polynomial, preset or bit order.
- The same good frames followed by three and by seven dribble bits, which show that partial octets never reach the register.
- A frame whose correct code sits three bits off an octet boundary, which separates a check over the last four octets from one over the last 32 bits.
- Single-bit corruption, frames shorter than the check field, and the four-octet boundary.
- Back-to-back frames with `rx_valid` held high through the status cycle, and a reset in mid-frame, which show that the preset and the ignore rules apply at the right cycles.

// File: rtl/fcs_chk_pkg.sv
package fcs_chk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RECV   = 2'd1,
        ST_REPORT = 2'd2
    } chk_state_t;

    localparam logic [31:0] ETH_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] ETH_PRESET  = 32'hFFFF_FFFF;
    localparam logic [31:0] ETH_RESIDUE = 32'hC704_DD7B;

endpackage

// File: rtl/octet_packer.sv
module octet_packer #(
    parameter int OCT_BITS = 8,
    localparam int IDX_W   = $clog2(OCT_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                bit_en,
    input  logic                bit_in,
    output logic                oct_strobe,
    output logic [OCT_BITS-1:0] oct_data,
    output logic [IDX_W-1:0]    fill
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(OCT_BITS - 1);

    logic [IDX_W-1:0]    fill_q;
    logic [OCT_BITS-2:0] hold_q;

    // Position of the next bit within the current octet
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fill_q <= '0;
        end else if (bit_en) begin
            fill_q <= (fill_q == LAST) ? '0 : fill_q + 1'b1;
        end
    end

    // One holding flop per early bit; the final bit goes straight out
    for (genvar g = 0; g < OCT_BITS - 1; g++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q[g] <= 1'b0;
            end else if (bit_en && fill_q == IDX_W'(g)) begin
                hold_q[g] <= bit_in;
            end
        end
    end

    assign oct_strobe = bit_en && (fill_q == LAST);
    assign oct_data   = {bit_in, hold_q};
    assign fill       = fill_q;

endmodule

// File: rtl/crc_octet_unit.sv
module crc_octet_unit #(
    parameter int                CRC_W  = 32,
    parameter int                DATA_W = 8,
    parameter logic [CRC_W-1:0]  POLY   = 32'h04C1_1DB7,
    parameter logic [CRC_W-1:0]  PRESET = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              preset,
    input  logic              upd,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] walk;
    logic             fb;

    // Octet-wide next state: the serial recurrence unrolled DATA_W times,
    // data bit 0 entering first, each bit XORed with the top of the register
    always_comb begin
        walk = crc_q;
        fb   = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            fb   = walk[CRC_W-1] ^ data[i];
            walk = {walk[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || preset) begin
            crc_q <= PRESET;
        end else if (upd) begin
            crc_q <= walk;
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/octet_tally.sv
module octet_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
        end else if (inc && count_q != TOP) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/fcs_octet_checker.sv
module fcs_octet_checker
    import fcs_chk_pkg::*;
#(
    parameter int               OCT_BITS = 8,
    parameter int               CRC_W    = 32,
    parameter int               CNT_W    = 16,
    parameter logic [CRC_W-1:0] POLY     = ETH_POLY,
    parameter logic [CRC_W-1:0] PRESET   = ETH_PRESET,
    parameter logic [CRC_W-1:0] RESIDUE  = ETH_RESIDUE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_bit,
    input  logic             rx_valid,
    output logic             status_valid,
    output logic             frame_ok,
    output logic [CNT_W-1:0] octet_count
);
    localparam int MIN_OCTETS = CRC_W / OCT_BITS;
    localparam int IDX_W      = $clog2(OCT_BITS);

    chk_state_t state_q, state_d;

    logic                bit_take;
    logic                rearm;
    logic                oct_strobe;
    logic [OCT_BITS-1:0] oct_data;
    logic [IDX_W-1:0]    part_fill;
    logic [CRC_W-1:0]    crc_val;
    logic [CNT_W-1:0]    tally;
    logic                frame_end;
    logic                enough;

    logic             status_q;
    logic             ok_q;
    logic [CNT_W-1:0] count_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (rx_valid)  state_d = ST_RECV;    // START
            ST_RECV:   if (!rx_valid) state_d = ST_REPORT;  // FINISH, else HOLD
            ST_REPORT:                state_d = ST_IDLE;    // REARM
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign bit_take  = rx_valid && (state_q != ST_REPORT);
    assign rearm     = (state_q == ST_REPORT);
    assign frame_end = (state_q == ST_RECV) && !rx_valid;
    assign enough    = (tally >= CNT_W'(MIN_OCTETS));

    octet_packer #(
        .OCT_BITS (OCT_BITS)
    ) u_packer (
        .clk        (clk),
        .rst        (rst),
        .clear      (rearm),
        .bit_en     (bit_take),
        .bit_in     (rx_bit),
        .oct_strobe (oct_strobe),
        .oct_data   (oct_data),
        .fill       (part_fill)
    );

    crc_octet_unit #(
        .CRC_W  (CRC_W),
        .DATA_W (OCT_BITS),
        .POLY   (POLY),
        .PRESET (PRESET)
    ) u_crc (
        .clk    (clk),
        .rst    (rst),
        .preset (rearm),
        .upd    (oct_strobe),
        .data   (oct_data),
        .crc    (crc_val)
    );

    octet_tally #(
        .CNT_W (CNT_W)
    ) u_tally (
        .clk   (clk),
        .rst   (rst),
        .clear (rearm),
        .inc   (oct_strobe),
        .count (tally)
    );

    // Output register: result is shown only in the REPORT cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= 1'b0;
            ok_q     <= 1'b0;
            count_q  <= '0;
        end else begin
            unique case (state_q)
                ST_RECV: begin
                    status_q <= frame_end;
                    ok_q     <= frame_end && enough && (crc_val == RESIDUE);
                    count_q  <= frame_end ? tally : '0;
                end
                default: begin
                    status_q <= 1'b0;
                    ok_q     <= 1'b0;
                    count_q  <= '0;
                end
            endcase
        end
    end

    assign status_valid = status_q;
    assign frame_ok     = ok_q;
    assign octet_count  = count_q;

endmodule

// File: rtl/fcs_chk_props.sv
module fcs_chk_props
    import fcs_chk_pkg::*;
#(
    parameter int               CRC_W      = 32,
    parameter int               CNT_W      = 16,
    parameter int               IDX_W      = 3,
    parameter int               MIN_OCTETS = 4,
    parameter logic [CRC_W-1:0] PRESET     = '1
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             status_valid,
    input logic             frame_ok,
    input logic [CNT_W-1:0] octet_count,
    input chk_state_t       state_q,
    input logic [CRC_W-1:0] crc_val,
    input logic [IDX_W-1:0] part_fill
);

    // R5
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        status_valid |=> !status_valid);

    // R5
    pulse_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        status_valid |-> ($past(!rx_valid) && $past(state_q == ST_RECV)));

    // R5
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        !status_valid |-> (!frame_ok && octet_count == '0));

    // R4
    short_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (status_valid && octet_count < CNT_W'(MIN_OCTETS)) |-> !frame_ok);

    // R8
    report_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REPORT) |=> (state_q == ST_IDLE && crc_val == PRESET && part_fill == '0));

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!status_valid && part_fill == '0 && crc_val == PRESET));

endmodule

bind fcs_octet_checker fcs_chk_props #(
    .CRC_W      (CRC_W),
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W),
    .MIN_OCTETS (MIN_OCTETS),
    .PRESET     (PRESET)
) u_props (
    .clk          (clk),
    .rst          (rst),
    .rx_valid     (rx_valid),
    .status_valid (status_valid),
    .frame_ok     (frame_ok),
    .octet_count  (octet_count),
    .state_q      (state_q),
    .crc_val      (crc_val),
    .part_fill    (part_fill)
);

// File: tb/fcs_octet_checker_test.sv
module fcs_octet_checker_test;

    localparam logic [31:0] GEN = 32'h04C1_1DB7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_bit = 1'b0;
    logic        rx_valid = 1'b0;
    logic        status_valid;
    logic        frame_ok;
    logic [15:0] octet_count;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    fcs_octet_checker uut (
        .clk          (clk),
        .rst          (rst),
        .rx_bit       (rx_bit),
        .rx_valid     (rx_valid),
        .status_valid (status_valid),
        .frame_ok     (frame_ok),
        .octet_count  (octet_count)
    );

    // ---------------- reference model ----------------
    int         m_mode = 0;      // 0 waiting, 1 in frame, 2 reporting
    logic       m_bits[$];
    logic       exp_sv = 1'b0;
    logic       exp_ok = 1'b0;
    int         exp_cnt = 0;
    string      cur_tag = "R1";

    logic       cap_new = 1'b0;
    logic       cap_ok = 1'b0;
    int         cap_cnt = 0;

    logic [7:0] by_q[$];
    logic       bit_q[$];

    function automatic logic [31:0] crc_over(logic [7:0] oq[$], int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < 8; i++) begin
                logic f = c[31] ^ oq[k][i];
                c = {c[30:0], 1'b0} ^ (f ? GEN : 32'h0);
            end
        end
        return c;
    endfunction

    function automatic logic [7:0] code_octet(logic [31:0] c, int k);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) o[i] = ~c[31 - (8 * k + i)];
        return o;
    endfunction

    task automatic model_edge(logic v, logic b);
        exp_sv  = 1'b0;
        exp_ok  = 1'b0;
        exp_cnt = 0;
        if (rst) begin
            m_mode = 0;
            m_bits.delete();
        end else if (m_mode == 2) begin
            m_mode = 0;
        end else if (v) begin
            m_bits.push_back(b);
            m_mode = 1;
        end else if (m_mode == 1) begin
            logic [7:0] oq[$];
            int n = m_bits.size() / 8;
            for (int k = 0; k < n; k++) begin
                logic [7:0] o;
                for (int i = 0; i < 8; i++) o[i] = m_bits[8 * k + i];
                oq.push_back(o);
            end
            exp_ok = 1'b0;
            if (n >= 4) begin
                logic [31:0] c = crc_over(oq, n - 4);
                exp_ok = 1'b1;
                for (int k = 0; k < 4; k++)
                    if (oq[n - 4 + k] != code_octet(c, k)) exp_ok = 1'b0;
            end
            exp_sv  = 1'b1;
            exp_cnt = n;
            m_bits.delete();
            m_mode = 2;
        end
    endtask

    task automatic compare();
        n_checks++;
        if (status_valid !== exp_sv) begin
            n_fail++;
            $display("FAIL R5: status_valid=%0b expected %0b", status_valid, exp_sv);
        end else if (frame_ok !== exp_ok) begin
            n_fail++;
            $display("FAIL %s: frame_ok=%0b expected %0b", cur_tag, frame_ok, exp_ok);
        end else if (octet_count !== 16'(exp_cnt)) begin
            n_fail++;
            $display("FAIL R6: octet_count=%0d expected %0d", octet_count, exp_cnt);
        end
        if (status_valid === 1'b1) begin
            cap_new = 1'b1;
            cap_ok  = frame_ok;
            cap_cnt = int'(octet_count);
        end
    endtask

    task automatic step(logic v, logic b);
        rx_valid = v;
        rx_bit   = b;
        model_edge(v, b);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic expect_result(logic eok, int ecnt, string tag);
        n_checks++;
        if (!cap_new || cap_ok !== eok || cap_cnt != ecnt) begin
            n_fail++;
            $display("FAIL %s: pulse=%0b ok=%0b count=%0d expected pulse=1 ok=%0b count=%0d",
                     tag, cap_new, cap_ok, cap_cnt, eok, ecnt);
        end
        cap_new = 1'b0;
    endtask

    // build helpers on the global queues
    task automatic make_payload(int n, int seed);
        by_q.delete();
        for (int k = 0; k < n; k++) by_q.push_back(8'((k * 37 + seed * 11 + 5) ^ (k >> 1)));
    endtask

    task automatic add_code();
        logic [31:0] c = crc_over(by_q, by_q.size());
        for (int k = 0; k < 4; k++) by_q.push_back(code_octet(c, k));
    endtask

    task automatic bytes_to_bits();
        bit_q.delete();
        foreach (by_q[k]) for (int i = 0; i < 8; i++) bit_q.push_back(by_q[k][i]);
    endtask

    task automatic drive_bits();
        foreach (bit_q[j]) step(1'b1, bit_q[j]);
    endtask

    task automatic close_frame();
        step(1'b0, 1'b0);   // edge sampling rx_valid low
    endtask

    task automatic finish_frame(logic eok, int ecnt, string tag);
        close_frame();
        expect_result(eok, ecnt, tag);
        step(1'b0, 1'b0);   // status cycle
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 10);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        @(negedge clk);
        step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        // R9: outputs quiet while reset held
        n_checks++;
        if (status_valid !== 1'b0 || frame_ok !== 1'b0 || octet_count !== 16'd0) begin
            n_fail++;
            $display("FAIL R9: status=%0b ok=%0b count=%0d expected 0 0 0",
                     status_valid, frame_ok, octet_count);
        end
        rst = 1'b0;
        step(1'b0, 1'b0);

        // R1 R6: aligned good frame
        cur_tag = "R1";
        make_payload(10, 1); add_code(); bytes_to_bits(); drive_bits();
        finish_frame(1'b1, 14, "R1");

        // R2: three dribble bits
        cur_tag = "R2";
        make_payload(10, 2); add_code(); bytes_to_bits();
        bit_q.push_back(1'b1); bit_q.push_back(1'b0); bit_q.push_back(1'b1);
        drive_bits();
        finish_frame(1'b1, 14, "R2");

        // R2: seven dribble bits
        make_payload(6, 3); add_code(); bytes_to_bits();
        for (int i = 0; i < 7; i++) bit_q.push_back(1'b1);
        drive_bits();
        finish_frame(1'b1, 10, "R2");

        // R3: correct code ends the stream but sits off the octet grid
        cur_tag = "R3";
        make_payload(8, 4);
        begin
            logic [31:0] c = crc_over(by_q, 8);
            bytes_to_bits();
            bit_q.push_back(1'b0); bit_q.push_back(1'b1); bit_q.push_back(1'b1);
            for (int j = 31; j >= 0; j--) bit_q.push_back(~c[j]);
        end
        drive_bits();
        finish_frame(1'b0, 12, "R3");

        // R7: one payload bit inverted
        cur_tag = "R7";
        make_payload(10, 5); add_code();
        by_q[3] = by_q[3] ^ 8'h10;
        bytes_to_bits(); drive_bits();
        finish_frame(1'b0, 14, "R7");

        // R4: three octets, a few bits, then exactly four octets
        cur_tag = "R4";
        make_payload(3, 6); bytes_to_bits(); drive_bits();
        finish_frame(1'b0, 3, "R4");
        bit_q.delete();
        for (int i = 0; i < 5; i++) bit_q.push_back(1'b1);
        drive_bits();
        finish_frame(1'b0, 0, "R4");
        by_q.delete(); add_code(); bytes_to_bits(); drive_bits();
        finish_frame(1'b1, 4, "R4");

        // R8: back to back, rx_valid high through the status cycle
        cur_tag = "R8";
        make_payload(5, 7); add_code(); bytes_to_bits(); drive_bits();
        close_frame();
        expect_result(1'b1, 9, "R8");
        step(1'b1, 1'b1);                // ignored during the status cycle
        make_payload(7, 8); add_code(); bytes_to_bits(); drive_bits();
        finish_frame(1'b1, 11, "R8");

        // R9: reset in mid-frame, then a good frame
        cur_tag = "R9";
        make_payload(9, 9); add_code(); bytes_to_bits();
        for (int j = 0; j < 21; j++) step(1'b1, bit_q[j]);
        rst = 1'b1;
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        rst = 1'b0;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        n_checks++;
        if (cap_new !== 1'b0) begin
            n_fail++;
            $display("FAIL R9: pulse after reset=%0b expected 0", cap_new);
        end
        cap_new = 1'b0;
        make_payload(12, 10); add_code(); bytes_to_bits(); drive_bits();
        finish_frame(1'b1, 16, "R9");

        // R1: longer frame
        cur_tag = "R1";
        make_payload(46, 11); add_code(); bytes_to_bits(); drive_bits();
        finish_frame(1'b1, 50, "R1");

        step(1'b0, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule